// File: doc/BRIEF.md
# Sprite Collision Scoring Game Controller

This block runs the game layer of a camera-driven video game. It keeps a fixed set of moving sprites: sprite 0 is the target and every other sprite is a decoy. Each sprite is placed at a pseudorandom horizontal position at the bottom of the screen. It rises by a fixed step on every slow tick and is placed again once its lifetime runs out. The lifetime comes from a two-bit difficulty input.

For every scan pixel, the block reports which sprite covers that pixel and the address of the matching word in that sprite's image memory. It reads back each sprite's colour and selects either a sprite colour or the camera colour for the display. Pure white sprite colour counts as see-through. When a visible sprite pixel falls inside the square around the hand cursor, that sprite is marked as hit and flips to its alternate image. Hitting the target adds a point and hitting a decoy wipes the score.

Top module: `spriteGameCtrl`

## Requirements
- R1: While reset is held, score is 0, altImage is all zero, every sprite y is H-SIZE (416), and sprite i has x = spawnX(seed i). Seed i is SEED_BASE + i*SEED_STEP modulo 2^16, and a seed of zero is replaced by 16'hACE1.
- R2: Each sprite owns a 16-bit LFSR that advances once per slow tick, which is one clock in every TICK_DIV. The LFSR shifts right, and if the bit shifted out was 1 the result is XORed with 16'hB400. On a respawn, x = spawnX(LFSR value before that tick's advance). spawnX(v) takes the low XW bits of v and subtracts W-SIZE when they are at least W-SIZE.
- R3: On a slow tick without respawn, sprite y drops by STEP and stops at 0. A respawn puts y back at H-SIZE. The first slow tick after reset is a respawn.
- R4: Difficulty 0, 1, 2, 3 gives a lifetime of 8, 6, 4, 2 times TICKS_PER_SEC slow ticks between respawns. The difficulty is read at each respawn.
- R5: pixOut shows the lowest-index sprite whose SIZE x SIZE box contains the scan pixel and whose colour is not 16'hFFFF. pixSrc is then that index plus 1. If no sprite qualifies, pixOut is camPix and pixSrc is 0.
- R6: The image address of sprite i is {scanY-y_i, scanX-x_i}, each field log2(SIZE) bits wide, with the row field in the upper bits.
- R7: A sprite collides when a non-white colour of it lies at a scan pixel inside the CUR x CUR cursor square. Its altImage bit goes high at the next edge and stays high until its next respawn, which clears it.
- R8: A collision with sprite 0 that is not yet hit adds 1 to the score, and this happens only once per lifetime.
- R9: A collision with a decoy that is not yet hit sets the score to 0. This takes priority over a target hit in the same cycle.
- R10: The score stops at 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| level | input | 2 | Difficulty selection, 3 hardest |
| scanX | input | XW | Current scan column |
| scanY | input | YW | Current scan row |
| cursorX | input | XW | Cursor square left edge |
| cursorY | input | YW | Cursor square top edge |
| camPix | input | 16 | Camera colour at the scan pixel |
| sprPix | input | NUM*16 | Image colour of each sprite at its address |
| pixOut | output | 16 | Selected display colour |
| pixSrc | output | clog2(NUM+1) | 0 for camera, i+1 for sprite i |
| sprAddr | output | NUM*2*log2(SIZE) | Image address per sprite |
| altImage | output | NUM | Per-sprite alternate image select (hit) |
| sprX | output | NUM*XW | Sprite left edges |
| sprY | output | NUM*YW | Sprite top edges |
| score | output | clog2(SCORE_MAX+1) | Current score |

## Verification
The assertions assume that the image colour on sprPix belongs to the address issued in the same cycle, and that scan and cursor coordinates stay on screen. The bench feeds sprite colours directly, and an opacity mask decides which sprites appear opaque. This lets each case choose exactly which sprites can collide. Collision stimulus is applied right after a tick edge and removed well before the next one, so it never falls in a respawn cycle, where the hit latch is cleared.

// File: rtl/spriteGamePkg.sv
package spriteGamePkg;
  localparam int SPR_MAX = 8;
  localparam logic [15:0] WHITE = 16'hFFFF;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;
  localparam logic [15:0] LFSR_FALLBACK = 16'hACE1;

  typedef struct packed {
    logic               tick;
    logic [SPR_MAX-1:0] respawn;
  } ctlStrobe_t;

  function automatic logic [15:0] lfsrNext(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/spriteControl.sv
module spriteControl
  import spriteGamePkg::*;
#(
  parameter int NUM       = 4,
  parameter int TICK_DIV  = 270000,
  parameter int TPS       = 100,
  parameter int SCORE_MAX = 99,
  parameter int SW        = $clog2(SCORE_MAX + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     level,
  input  logic [NUM-1:0] collide,
  output ctlStrobe_t     strobe,
  output logic [NUM-1:0] hit,
  output logic [SW-1:0]  score
);
  localparam int DW = $clog2(TICK_DIV);
  localparam int LW = $clog2(8 * TPS);

  logic [DW-1:0]  divCnt;
  logic           tick;
  logic [NUM-1:0] respawnVec;
  logic [NUM-1:0] fresh;
  logic           targetHit, decoyHit;

  function automatic logic [LW-1:0] lifeLoad(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return LW'(8 * TPS - 1);
      2'd1:    return LW'(6 * TPS - 1);
      2'd2:    return LW'(4 * TPS - 1);
      default: return LW'(2 * TPS - 1);
    endcase
  endfunction

  assign tick = (divCnt == DW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN || tick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  for (genvar i = 0; i < NUM; i++) begin : g_life
    logic [LW-1:0] lifeLeft;
    assign respawnVec[i] = tick && (lifeLeft == '0);

    always_ff @(posedge clk) begin
      if (!rstN)              lifeLeft <= '0;
      else if (respawnVec[i]) lifeLeft <= lifeLoad(level);
      else if (tick)          lifeLeft <= lifeLeft - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN)              hit[i] <= 1'b0;
      else if (respawnVec[i]) hit[i] <= 1'b0;
      else if (collide[i])    hit[i] <= 1'b1;
    end

    // R7: a hit latch survives every cycle until its respawn
    p_hit_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
      (hit[i] && !respawnVec[i]) |=> hit[i]);
  end

  assign strobe.tick    = tick;
  assign strobe.respawn = SPR_MAX'(respawnVec);

  assign fresh     = collide & ~hit & ~respawnVec;
  assign targetHit = fresh[0];
  assign decoyHit  = |fresh[NUM-1:1];

  always_ff @(posedge clk) begin
    if (!rstN)                                  score <= '0;
    else if (decoyHit)                          score <= '0;
    else if (targetHit && score < SW'(SCORE_MAX)) score <= score + 1'b1;
  end

  p_score_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    score <= SW'(SCORE_MAX));

  // R8 R9: score only steps by one or drops to zero
  p_score_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (score == $past(score) || score == $past(score) + 1'b1 || score == '0));

  p_decoy_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    decoyHit |=> score == '0);
endmodule

// File: rtl/spriteDatapath.sv
module spriteDatapath
  import spriteGamePkg::*;
#(
  parameter int          NUM       = 4,
  parameter int          XW        = 10,
  parameter int          YW        = 10,
  parameter int          SCREEN_W  = 640,
  parameter int          SCREEN_H  = 480,
  parameter int          SIZE      = 64,
  parameter int          CUR       = 8,
  parameter int          STEP      = 1,
  parameter logic [15:0] SEED_BASE = 16'h1D2C,
  parameter logic [15:0] SEED_STEP = 16'h3B5D,
  parameter int          AW        = 2 * $clog2(SIZE),
  parameter int          PSW       = $clog2(NUM + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [XW-1:0]     scanX,
  input  logic [YW-1:0]     scanY,
  input  logic [XW-1:0]     cursorX,
  input  logic [YW-1:0]     cursorY,
  input  logic [15:0]       camPix,
  input  logic [NUM*16-1:0] sprPix,
  output logic [NUM-1:0]    collide,
  output logic [15:0]       pixOut,
  output logic [PSW-1:0]    pixSrc,
  output logic [NUM*AW-1:0] sprAddr,
  output logic [NUM*XW-1:0] sprX,
  output logic [NUM*YW-1:0] sprY
);
  localparam int            SB     = AW / 2;
  localparam int            SPAN   = SCREEN_W - SIZE;
  localparam logic [YW-1:0] BOTTOM = YW'(SCREEN_H - SIZE);

  logic [NUM-1:0] opaque;
  logic           inCursor;

  function automatic logic [XW-1:0] spawnX(input logic [15:0] s);
    logic [XW-1:0] v;
    v = s[XW-1:0];
    return (v >= XW'(SPAN)) ? v - XW'(SPAN) : v;
  endfunction

  assign inCursor = ({1'b0, scanX} >= {1'b0, cursorX}) &&
                    ({1'b0, scanX} <  {1'b0, cursorX} + (XW+1)'(CUR)) &&
                    ({1'b0, scanY} >= {1'b0, cursorY}) &&
                    ({1'b0, scanY} <  {1'b0, cursorY} + (YW+1)'(CUR));

  for (genvar i = 0; i < NUM; i++) begin : g_spr
    localparam logic [15:0] RAW  = 16'(SEED_BASE + 16'(i) * SEED_STEP);
    localparam logic [15:0] SEED = (RAW == 16'h0) ? LFSR_FALLBACK : RAW;

    logic [15:0]   lfsr;
    logic [XW-1:0] posX;
    logic [YW-1:0] posY;
    logic          inBox;
    logic [XW-1:0] dx;
    logic [YW-1:0] dy;

    always_ff @(posedge clk) begin
      if (!rstN)            lfsr <= SEED;
      else if (strobe.tick) lfsr <= lfsrNext(lfsr);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        posX <= spawnX(SEED);
        posY <= BOTTOM;
      end else if (strobe.respawn[i]) begin
        posX <= spawnX(lfsr);
        posY <= BOTTOM;
      end else if (strobe.tick) begin
        posY <= (posY >= YW'(STEP)) ? posY - YW'(STEP) : '0;
      end
    end

    assign inBox = ({1'b0, scanX} >= {1'b0, posX}) &&
                   ({1'b0, scanX} <  {1'b0, posX} + (XW+1)'(SIZE)) &&
                   ({1'b0, scanY} >= {1'b0, posY}) &&
                   ({1'b0, scanY} <  {1'b0, posY} + (YW+1)'(SIZE));

    assign dx         = scanX - posX;
    assign dy         = scanY - posY;
    assign opaque[i]  = inBox && (sprPix[i*16 +: 16] != WHITE);
    assign collide[i] = opaque[i] && inCursor;

    assign sprAddr[i*AW +: AW] = {dy[SB-1:0], dx[SB-1:0]};
    assign sprX[i*XW +: XW]    = posX;
    assign sprY[i*YW +: YW]    = posY;

    p_lfsr_live_r2: assert property (@(posedge clk) disable iff (!rstN)
      lfsr != 16'h0);
    p_x_range_r2: assert property (@(posedge clk) disable iff (!rstN)
      posX <= XW'(SPAN));
    p_spawn_bottom_r3: assert property (@(posedge clk) disable iff (!rstN)
      strobe.respawn[i] |=> posY == BOTTOM);
  end

  always_comb begin
    pixOut = camPix;
    pixSrc = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (opaque[i]) begin
        pixOut = sprPix[i*16 +: 16];
        pixSrc = PSW'(i + 1);
      end
    end
  end

  // R5: a sprite source never shows see-through white
  p_no_white_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pixSrc != '0) |-> (pixOut != WHITE));
endmodule

// File: rtl/spriteGameCtrl.sv
module spriteGameCtrl
  import spriteGamePkg::*;
#(
  parameter int          NUM       = 4,
  parameter int          XW        = 10,
  parameter int          YW        = 10,
  parameter int          SCREEN_W  = 640,
  parameter int          SCREEN_H  = 480,
  parameter int          SIZE      = 64,
  parameter int          CUR       = 8,
  parameter int          STEP      = 1,
  parameter int          TICK_DIV  = 270000,
  parameter int          TPS       = 100,
  parameter int          SCORE_MAX = 99,
  parameter logic [15:0] SEED_BASE = 16'h1D2C,
  parameter logic [15:0] SEED_STEP = 16'h3B5D
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [1:0]                         level,
  input  logic [XW-1:0]                      scanX,
  input  logic [YW-1:0]                      scanY,
  input  logic [XW-1:0]                      cursorX,
  input  logic [YW-1:0]                      cursorY,
  input  logic [15:0]                        camPix,
  input  logic [NUM*16-1:0]                  sprPix,
  output logic [15:0]                        pixOut,
  output logic [$clog2(NUM+1)-1:0]           pixSrc,
  output logic [NUM*2*$clog2(SIZE)-1:0]      sprAddr,
  output logic [NUM-1:0]                     altImage,
  output logic [NUM*XW-1:0]                  sprX,
  output logic [NUM*YW-1:0]                  sprY,
  output logic [$clog2(SCORE_MAX+1)-1:0]     score
);
  ctlStrobe_t     strobe;
  logic [NUM-1:0] collide;

  spriteControl #(
    .NUM(NUM), .TICK_DIV(TICK_DIV), .TPS(TPS), .SCORE_MAX(SCORE_MAX)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .level(level), .collide(collide),
    .strobe(strobe), .hit(altImage), .score(score)
  );

  spriteDatapath #(
    .NUM(NUM), .XW(XW), .YW(YW), .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H),
    .SIZE(SIZE), .CUR(CUR), .STEP(STEP),
    .SEED_BASE(SEED_BASE), .SEED_STEP(SEED_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .scanX(scanX), .scanY(scanY), .cursorX(cursorX), .cursorY(cursorY),
    .camPix(camPix), .sprPix(sprPix), .collide(collide),
    .pixOut(pixOut), .pixSrc(pixSrc), .sprAddr(sprAddr),
    .sprX(sprX), .sprY(sprY)
  );
endmodule

// File: tb/spriteGameCtrl_test.sv
`timescale 1ns/1ps
module spriteGameCtrl_test;
  localparam int NUM = 4, XW = 10, YW = 10, SIZE = 64, DIV = 16, TPS = 2, STEP = 32;
  localparam int SPAN = 640 - SIZE, BOT = 480 - SIZE;
  localparam logic [15:0] SBASE = 16'h0000, SSTEP = 16'h3B5D, CAM = 16'h0BAD;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        level = 2'd0;
  logic [XW-1:0]     scanX = '0;
  logic [YW-1:0]     scanY = '0;
  logic [XW-1:0]     cursorX = 10'd620;
  logic [YW-1:0]     cursorY = '0;
  logic [15:0]       camPix = CAM;
  logic [NUM*16-1:0] sprPix = '1;
  logic [15:0]       pixOut;
  logic [2:0]        pixSrc;
  logic [NUM*12-1:0] sprAddr;
  logic [NUM-1:0]    altImage;
  logic [NUM*XW-1:0] sprX;
  logic [NUM*YW-1:0] sprY;
  logic [6:0]        score;

  int checks = 0, fails = 0;
  int cycCnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycCnt <= rstN ? cycCnt + 1 : 0;

  spriteGameCtrl #(
    .NUM(NUM), .STEP(STEP), .TICK_DIV(DIV), .TPS(TPS),
    .SEED_BASE(SBASE), .SEED_STEP(SSTEP)
  ) uut (
    .clk(clk), .rstN(rstN), .level(level), .scanX(scanX), .scanY(scanY),
    .cursorX(cursorX), .cursorY(cursorY), .camPix(camPix), .sprPix(sprPix),
    .pixOut(pixOut), .pixSrc(pixSrc), .sprAddr(sprAddr), .altImage(altImage),
    .sprX(sprX), .sprY(sprY), .score(score)
  );

  typedef struct packed {
    logic [9:0] sx;
    logic [9:0] sy;
    logic [3:0] mask;
    logic [2:0] src;
  } vec_t;

  // positions at reset: x = 225, 285, 122, 535; y = 416
  localparam vec_t VECS [10] = '{
    '{10'd230, 10'd420, 4'b1111, 3'd1},
    '{10'd286, 10'd420, 4'b1111, 3'd1},
    '{10'd286, 10'd420, 4'b1110, 3'd2},
    '{10'd300, 10'd420, 4'b1111, 3'd2},
    '{10'd130, 10'd450, 4'b1111, 3'd3},
    '{10'd540, 10'd479, 4'b1111, 3'd4},
    '{10'd540, 10'd479, 4'b0111, 3'd0},
    '{10'd10,  10'd10,  4'b1111, 3'd0},
    '{10'd225, 10'd415, 4'b1111, 3'd0},
    '{10'd288, 10'd416, 4'b1100, 3'd0}
  };

  function automatic logic [15:0] seedOf(input int i);
    logic [15:0] s = 16'(SBASE + 16'(i) * SSTEP);
    return (s == 16'h0) ? 16'hACE1 : s;
  endfunction

  function automatic logic [15:0] adv(input logic [15:0] s, input int n);
    logic [15:0] v = s;
    for (int k = 0; k < n; k++) begin
      logic out = v[0];
      v = v >> 1;
      if (out) v = v ^ 16'hB400;
    end
    return v;
  endfunction

  function automatic int spawnX(input logic [15:0] s);
    int v = int'(s[9:0]);
    return (v >= SPAN) ? v - SPAN : v;
  endfunction

  function automatic int xOf(input int i); return int'(sprX[i*XW +: XW]); endfunction
  function automatic int yOf(input int i); return int'(sprY[i*YW +: YW]); endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setMask(input logic [3:0] m);
    for (int i = 0; i < NUM; i++)
      sprPix[i*16 +: 16] = m[i] ? 16'(16'h1000 + i) : 16'hFFFF;
  endtask

  task automatic idle();
    setMask(4'b0000);
    cursorX = 10'd620;
    cursorY = '0;
  endtask

  task automatic stepCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitTick();
    do stepCyc(1); while (cycCnt % DIV != 0);
  endtask

  task automatic waitTicks(input int n);
    while (cycCnt / DIV < n) waitTick();
  endtask

  task automatic aimAt(input int x, input int y, input logic [3:0] m);
    scanX = XW'(x); scanY = YW'(y);
    cursorX = XW'(x); cursorY = YW'(y);
    setMask(m);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    setMask(4'b0000);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 score", score, 0);
    check("R1 alt", altImage, 0);
    check("R1 x0 zero seed", xOf(0), spawnX(16'hACE1));
    check("R1 x3", xOf(3), spawnX(seedOf(3)));
    check("R1 y2", yOf(2), BOT);
    @(posedge clk); #1;
    rstN = 1'b1;

    // R5 pixel selection table
    foreach (VECS[k]) begin
      scanX = VECS[k].sx; scanY = VECS[k].sy; setMask(VECS[k].mask);
      #1;
      check("R5 src", pixSrc, VECS[k].src);
      check("R5 pix", pixOut, (VECS[k].src == 0) ? CAM : 16'h1000 + VECS[k].src - 1);
    end
    // R6 address fields
    scanX = 10'd230; scanY = 10'd420; #1;
    check("R6 addr0", sprAddr[11:0], (4 << 6) | 5);
    scanX = 10'd130; scanY = 10'd450; #1;
    check("R6 addr2", sprAddr[2*12 +: 12], (34 << 6) | 8);

    // R7/R8 target hit, counted once
    cursorX = 10'd228; cursorY = 10'd418; scanX = 10'd230; scanY = 10'd420;
    setMask(4'b0001);
    stepCyc(1);
    check("R8 target +1", score, 1);
    check("R7 alt0 set", altImage[0], 1);
    stepCyc(2);
    check("R8 once per life", score, 1);
    idle();

    waitTicks(1);
    check("R7 cleared on respawn", altImage, 0);
    check("R2 first respawn x", xOf(0), spawnX(16'hACE1));
    check("R3 respawn y", yOf(0), BOT);

    // R9 decoy wins over fresh target in same cycle
    cursorX = 10'd283; cursorY = 10'd418; scanX = 10'd286; scanY = 10'd420;
    setMask(4'b1111);
    stepCyc(1);
    check("R9 priority clear", score, 0);
    check("R7 alt0/1", altImage[1:0], 3);
    idle();

    waitTicks(2);
    check("R3 step up", yOf(0), BOT - STEP);
    waitTicks(10);
    level = 2'd3;
    waitTicks(16);
    check("R3 clamp at 0", yOf(0), 0);
    waitTicks(17);
    check("R4 level0 life y", yOf(0), BOT);
    check("R2 respawn x0", xOf(0), spawnX(adv(16'hACE1, 16)));
    waitTicks(20);
    check("R4 level3 pending", yOf(0), BOT - 3 * STEP);
    waitTicks(21);
    check("R4 level3 respawn", yOf(0), BOT);
    check("R2 x0 tick21", xOf(0), spawnX(adv(16'hACE1, 20)));
    check("R2 x1 tick21", xOf(1), spawnX(adv(seedOf(1), 20)));

    // R10 saturation over repeated lifetimes
    for (int k = 0; k < 100; k++) begin
      if (k > 0) begin
        do waitTick(); while (yOf(0) != BOT);
      end
      aimAt(xOf(0), yOf(0), 4'b0001);
      stepCyc(1);
      idle();
      check("R10 score count", score, (k + 1 > 99) ? 99 : k + 1);
    end

    // R9 decoy alone clears
    aimAt(xOf(2), yOf(2), 4'b0100);
    stepCyc(1);
    check("R9 decoy clear", score, 0);
    check("R7 alt2", altImage[2], 1);
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule